// File: doc/BRIEF.md
# Lockstep Fault Manager

This block sits beside a pair of processors that run the same program in lockstep. On every cycle in which either processor drives its output bus, it compares the two buses. It merges the result with fault lines from the neighbouring memory, I/O and bus blocks and with an internal self-check line, and records the cause of every fault in sticky flags.

A first fault asks the processor pair to roll back. Once the pair reports that the rollback is finished, a window of programmable length opens. A second fault inside that window is treated as a recurrence. Depending on a mode input, the block then either stops both processors and blocks every output in the same cycle, or keeps running on one processor chosen by a configuration input and flags deferred maintenance. A quiet window returns the block to normal dual operation.

The block also grants the internal bus to one requester at a time using fixed priority. Requester 0 is the DMA channel and has the highest priority.

Top module: `lockstep_fault_mgr`

## Requirements
- R1: In dual operation, a cycle in which at least one processor valid is high is a mismatch when the two valids differ, or when both are high and the data words differ.
- R2: Any high bit of `ext_fault`, or a high `int_fault`, is a fault exactly like a mismatch.
- R3: A fault in normal operation drives `rollback_req` high from the next cycle. It stays high up to and including the cycle in which `rb_done` is sampled high, and drops on the cycle after. Faults that arrive while rollback is pending cause no further state change.
- R4: After the cycle in which `rb_done` is taken, the next `win_cycles`+1 cycles form the recurrence window. If those cycles are fault-free, the block returns to normal operation, and a later fault starts a new rollback.
- R5: When a fault occurs inside the window and `recur_solo` is 0, `halt_cpus` rises in that same cycle. In that cycle `out_vld` and `out_data` are forced to zero. Both conditions hold until reset.
- R6: When a fault occurs inside the window and `recur_solo` is 1, `solo_maint` rises on the next cycle and stays high until reset. While it is high, the outputs follow processor B if `keep_b` is 1 and processor A if `keep_b` is 0, and processor disagreements are not faults.
- R7: `fault_cause` bit 0 (mismatch), bit 1 (external) and bit 2 (internal) are each set on the cycle after their condition occurs. They are cleared only by reset.
- R8: `bus_gnt` is combinational and has at most one bit set: the lowest-numbered requester that is asserting its request. Requester 0 is the DMA channel.
- R9: No grant is issued while `halt_cpus` is high, including the cycle of the halt decision.
- R10: After reset, `rollback_req`, `halt_cpus`, `solo_maint` and `fault_cause` are all zero.
- R11: Outside single-processor and halt operation, `out_data` and `out_vld` carry processor A's bus unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_a_data | input | DW | Output bus of processor A |
| cpu_a_vld | input | 1 | Processor A bus valid |
| cpu_b_data | input | DW | Output bus of processor B |
| cpu_b_vld | input | 1 | Processor B bus valid |
| ext_fault | input | N_EXT | Fault lines from neighbouring blocks |
| int_fault | input | 1 | Internal self-check fault |
| recur_solo | input | 1 | Recurrence action: 0 halt, 1 single processor |
| keep_b | input | 1 | Processor kept in single mode: 0 A, 1 B |
| rb_done | input | 1 | Rollback complete from processor pair |
| win_cycles | input | WIN_W | Recurrence window length minus one |
| bus_req | input | N_REQ | Bus requests, index 0 is DMA |
| out_data | output | DW | Module output bus |
| out_vld | output | 1 | Module output valid |
| rollback_req | output | 1 | Rollback/restart request |
| halt_cpus | output | 1 | Halt both processors, outputs inhibited |
| solo_maint | output | 1 | Single-processor operation, maintenance deferred |
| fault_cause | output | 3 | Sticky causes: [0] mismatch, [1] external, [2] internal |
| bus_gnt | output | N_REQ | One-hot bus grant |

## Verification
If the recovery state is wrong, the ports show it within one cycle. `rollback_req`, `halt_cpus` and `solo_maint` expose the state directly. A misplaced window count shows up as a fault that escalates when it should have rolled back, or the reverse, in the cycle after the fault. A wrong halt decision is visible in the same cycle through the output gate and the grant vector. A lost or wrongly cleared cause flag shows on `fault_cause` one cycle after the event and stays visible from then on.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
   typedef enum logic [2:0] {
      LFM_RUN,
      LFM_RECOVER,
      LFM_WATCH,
      LFM_HALT,
      LFM_SOLO
   } lfm_state_e;

   localparam int CAUSE_W        = 3;
   localparam int CAUSE_MISMATCH = 0;
   localparam int CAUSE_EXT      = 1;
   localparam int CAUSE_INT      = 2;
endpackage

// File: rtl/lfm_compare.sv
module lfm_compare #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a_data,
   input  logic          a_vld,
   input  logic [DW-1:0] b_data,
   input  logic          b_vld,
   input  logic          cmp_en,
   output logic          mismatch
);
   // R1: valid disagreement, or data disagreement while both are valid
   logic vld_diff;
   logic data_diff;

   assign vld_diff  = a_vld ^ b_vld;
   assign data_diff = a_vld & b_vld & (a_data != b_data);
   assign mismatch  = cmp_en & (vld_diff | data_diff);
endmodule

// File: rtl/lfm_recovery.sv
module lfm_recovery
   import lfm_pkg::*;
#(
   parameter int WIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fault,
   input  logic             rb_done,
   input  logic [WIN_W-1:0] win_cycles,
   input  logic             recur_solo,
   output lfm_state_e       state,
   output logic             halt_now
);
   lfm_state_e       st;
   logic [WIN_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= LFM_RUN;
         cnt <= '0;
      end else begin
         unique case (st)
            LFM_RUN:     if (fault) st <= LFM_RECOVER;        // R3
            LFM_RECOVER: if (rb_done) begin                   // R3
               st  <= LFM_WATCH;
               cnt <= win_cycles;
            end
            LFM_WATCH: begin                                  // R4
               if (fault)         st  <= recur_solo ? LFM_SOLO : LFM_HALT;
               else if (cnt == '0) st <= LFM_RUN;
               else               cnt <= cnt - 1'b1;
            end
            default: ;                                        // HALT, SOLO hold
         endcase
      end
   end

   // R5: halt takes effect in the decision cycle
   always_comb begin
      halt_now = (st == LFM_HALT) ||
                 ((st == LFM_WATCH) && fault && !recur_solo);
   end

   assign state = st;
endmodule

// File: rtl/lfm_arbiter.sv
module lfm_arbiter #(
   parameter int N_REQ = 4
) (
   input  logic [N_REQ-1:0] req,
   input  logic             enable,
   output logic [N_REQ-1:0] gnt
);
   // R8: lower index wins; blocked[i] marks a higher-priority request
   logic [N_REQ:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N_REQ; i++) begin : g_slot
      assign blocked[i+1] = blocked[i] | req[i];
      assign gnt[i]       = enable & req[i] & ~blocked[i];   // R9 via enable
   end
endmodule

// File: rtl/lockstep_fault_mgr.sv
module lockstep_fault_mgr
   import lfm_pkg::*;
#(
   parameter int DW    = 16,
   parameter int N_EXT = 4,
   parameter int N_REQ = 4,
   parameter int WIN_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DW-1:0]      cpu_a_data,
   input  logic               cpu_a_vld,
   input  logic [DW-1:0]      cpu_b_data,
   input  logic               cpu_b_vld,
   input  logic [N_EXT-1:0]   ext_fault,
   input  logic               int_fault,
   input  logic               recur_solo,
   input  logic               keep_b,
   input  logic               rb_done,
   input  logic [WIN_W-1:0]   win_cycles,
   input  logic [N_REQ-1:0]   bus_req,
   output logic [DW-1:0]      out_data,
   output logic               out_vld,
   output logic               rollback_req,
   output logic               halt_cpus,
   output logic               solo_maint,
   output logic [CAUSE_W-1:0] fault_cause,
   output logic [N_REQ-1:0]   bus_gnt
);
   if (DW < 1)    begin : g_bad_dw  $error("DW must be at least 1");    end
   if (N_EXT < 1) begin : g_bad_ext $error("N_EXT must be at least 1"); end
   if (N_REQ < 1) begin : g_bad_req $error("N_REQ must be at least 1"); end
   if (WIN_W < 1) begin : g_bad_win $error("WIN_W must be at least 1"); end

   lfm_state_e         state;
   logic               halt_now;
   logic               mismatch;
   logic               fault_any;
   logic               sel_b;
   logic [CAUSE_W-1:0] cause_evt;
   logic [CAUSE_W-1:0] cause_q;

   lfm_compare #(.DW(DW)) u_cmp (
      .a_data   (cpu_a_data),
      .a_vld    (cpu_a_vld),
      .b_data   (cpu_b_data),
      .b_vld    (cpu_b_vld),
      .cmp_en   (state != LFM_SOLO),     // R6: no comparison in single mode
      .mismatch (mismatch)
   );

   // R2: all fault sources merged into one condition
   assign cause_evt[CAUSE_MISMATCH] = mismatch;
   assign cause_evt[CAUSE_EXT]      = |ext_fault;
   assign cause_evt[CAUSE_INT]      = int_fault;
   assign fault_any                 = |cause_evt;

   lfm_recovery #(.WIN_W(WIN_W)) u_rec (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault      (fault_any),
      .rb_done    (rb_done),
      .win_cycles (win_cycles),
      .recur_solo (recur_solo),
      .state      (state),
      .halt_now   (halt_now)
   );

   // R7: sticky cause flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_q | cause_evt;
   end

   lfm_arbiter #(.N_REQ(N_REQ)) u_arb (
      .req    (bus_req),
      .enable (!halt_now),
      .gnt    (bus_gnt)
   );

   // R5, R6, R11: output selection and inhibit
   assign sel_b    = (state == LFM_SOLO) && keep_b;
   assign out_data = halt_now ? '0 : (sel_b ? cpu_b_data : cpu_a_data);
   assign out_vld  = !halt_now && (sel_b ? cpu_b_vld : cpu_a_vld);

   assign rollback_req = (state == LFM_RECOVER);
   assign halt_cpus    = halt_now;
   assign solo_maint   = (state == LFM_SOLO);
   assign fault_cause  = cause_q;
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
   parameter int N_REQ = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_vld,
   input logic             rollback_req,
   input logic             halt_cpus,
   input logic             solo_maint,
   input logic [2:0]       fault_cause,
   input logic [N_REQ-1:0] bus_gnt
);
   // R5
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cpus |=> halt_cpus);

   // R5
   halt_gates_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cpus |-> !out_vld);

   // R6
   solo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      solo_maint |=> (solo_maint && !halt_cpus));

   // R3
   rollback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_req |-> (!halt_cpus && !solo_maint));

   // R7
   cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fault_cause & $past(fault_cause)) == $past(fault_cause)));

   // R8
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_gnt));

   // R9
   no_gnt_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cpus |-> (bus_gnt == '0));
endmodule

bind lockstep_fault_mgr lfm_checker #(.N_REQ(N_REQ)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_vld      (out_vld),
   .rollback_req (rollback_req),
   .halt_cpus    (halt_cpus),
   .solo_maint   (solo_maint),
   .fault_cause  (fault_cause),
   .bus_gnt      (bus_gnt)
);

// File: tb/lockstep_fault_mgr_test.sv
module lockstep_fault_mgr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a_d = '0, b_d = '0;
   logic        a_v = 1'b0, b_v = 1'b0;
   logic [3:0]  ext = '0;
   logic        intf = 1'b0, solo_sel = 1'b0, kb = 1'b0, rbd = 1'b0;
   logic [7:0]  win = 8'd3;
   logic [3:0]  req = '0;
   logic [15:0] o_d;
   logic        o_v, rb_req, halt, solo;
   logic [2:0]  cause;
   logic [3:0]  gnt;

   int vectors = 0, miscompares = 0;
   bit done = 0;

   // reference model state: 0 run, 1 rollback pending, 2 window, 3 halted, 4 single
   int          m_mode;
   int          m_cnt;
   logic [2:0]  m_cause;

   always #10 clk = ~clk;

   lockstep_fault_mgr uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_a_data(a_d), .cpu_a_vld(a_v), .cpu_b_data(b_d), .cpu_b_vld(b_v),
      .ext_fault(ext), .int_fault(intf), .recur_solo(solo_sel), .keep_b(kb),
      .rb_done(rbd), .win_cycles(win), .bus_req(req),
      .out_data(o_d), .out_vld(o_v), .rollback_req(rb_req), .halt_cpus(halt),
      .solo_maint(solo), .fault_cause(cause), .bus_gnt(gnt)
   );

   task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_mode = 0; m_cnt = 0; m_cause = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive at falling edge, compare mid-phase, update model at rising edge
   task automatic step(logic [15:0] ad, logic av, logic [15:0] bd, logic bv,
                       logic [3:0] e, logic i_f, logic rb, logic [3:0] rq);
      bit mm, flt, halt_x, selb;
      logic [3:0] g_x;
      @(negedge clk);
      a_d = ad; a_v = av; b_d = bd; b_v = bv; ext = e; intf = i_f; rbd = rb; req = rq;
      #5;
      mm     = (m_mode != 4) && (av || bv) && ((av != bv) || (ad != bd));   // R1
      flt    = mm || (e != 0) || i_f;                                       // R2
      halt_x = (m_mode == 3) || (m_mode == 2 && flt && !solo_sel);
      selb   = (m_mode == 4) && kb;
      g_x    = '0;
      if (!halt_x)
         for (int k = 0; k < 4; k++)
            if (rq[k]) begin g_x[k] = 1'b1; break; end
      chk("R11/R6/R5", "out_data", 32'(o_d), halt_x ? 32'd0 : 32'(selb ? bd : ad));
      chk("R11/R6/R5", "out_vld", 32'(o_v), 32'(!halt_x && (selb ? bv : av)));
      chk("R3", "rollback_req", 32'(rb_req), 32'(m_mode == 1));
      chk("R5", "halt_cpus", 32'(halt), 32'(halt_x));
      chk("R6", "solo_maint", 32'(solo), 32'(m_mode == 4));
      chk("R7", "fault_cause", 32'(cause), 32'(m_cause));
      chk("R8/R9", "bus_gnt", 32'(gnt), 32'(g_x));
      @(posedge clk);
      m_cause = m_cause | {i_f, (e != 0), mm};
      case (m_mode)
         0: if (flt) m_mode = 1;
         1: if (rb) begin m_mode = 2; m_cnt = int'(win); end
         2: if (flt) m_mode = solo_sel ? 4 : 3;
            else if (m_cnt == 0) m_mode = 0;
            else m_cnt--;
         default: ;
      endcase
   endtask

   task automatic idle(int n, logic [3:0] rq);
      for (int k = 0; k < n; k++) step(16'h1234, 1'b1, 16'h1234, 1'b1, 4'h0, 1'b0, 1'b0, rq);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R3 actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R10: reset state
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0);
      // R11, R8: matched traffic with several request patterns
      step(16'hAAAA, 1'b1, 16'hAAAA, 1'b1, 4'h0, 1'b0, 1'b0, 4'b1010);
      step(16'h5555, 1'b1, 16'h5555, 1'b1, 4'h0, 1'b0, 1'b0, 4'b1100);
      step(16'h0F0F, 1'b1, 16'h0F0F, 1'b1, 4'h0, 1'b0, 1'b1, 4'b1111);
      step(16'h00FF, 1'b0, 16'h00FF, 1'b0, 4'h0, 1'b0, 1'b0, 4'b1000);
      // R1: data mismatch triggers rollback (R3)
      step(16'h0005, 1'b1, 16'h0006, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0);
      idle(2, 4'b0001);
      // R3: fault while rollback pending changes no state, R7 records external
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'b0100, 1'b0, 1'b0, 4'h0);
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, 1'b1, 4'h0);
      // R4: quiet window of win+1 cycles returns to normal
      idle(4, 4'b0110);
      // R2: external fault after window gives fresh rollback
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'b0001, 1'b0, 1'b0, 4'h0);
      idle(1, 4'h0);
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, 1'b1, 4'h0);
      idle(3, 4'h0);
      // R5: internal fault in last window cycle halts at once, R9 no grant
      step(16'hBEEF, 1'b1, 16'hBEEF, 1'b1, 4'h0, 1'b1, 1'b0, 4'b0011);
      idle(3, 4'b1111);
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, 1'b1, 4'b0001);

      // second run: single-processor path with the shortest window
      do_reset();
      win = 8'd0; solo_sel = 1'b1; kb = 1'b1;
      // R1: valid-only mismatch
      step(16'h0011, 1'b1, 16'h0011, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0);
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, 1'b1, 4'h0);
      // R6: external fault inside the one-cycle window selects single mode
      step(16'h0, 1'b0, 16'h0, 1'b0, 4'b1000, 1'b0, 1'b0, 4'h0);
      // R6: B is output, disagreements are no fault
      step(16'h1111, 1'b1, 16'h2222, 1'b1, 4'h0, 1'b0, 1'b0, 4'b0100);
      step(16'h3333, 1'b0, 16'h4444, 1'b1, 4'h0, 1'b0, 1'b0, 4'h0);
      kb = 1'b0;
      step(16'h5555, 1'b1, 16'h6666, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0);
      // R7: internal cause recorded in single mode
      step(16'h7777, 1'b1, 16'h7777, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0);
      idle(2, 4'h0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule